// File: doc/BRIEF.md
# Priority-List Multi-Channel Request Arbiter

This block sits between a set of dedicated requester ports and a small number of service channels. Every requester owns its own port, made of a valid flag and a payload word. In each cycle the arbiter walks a programmable ordered list of ports, starting at the first slot. It accepts valid requests in list order until every channel is filled. Accepted requests leave on the channel outputs, packed from channel 0 upward. A requester that is not accepted sees its ready flag low and keeps presenting its request.

Software rewrites the ordered list one slot at a time through a configuration write port. This lets it rotate priorities against starvation or shape bandwidth. A written slot takes effect in the cycle after the write. Reset loads the identity order, so port 0 ranks highest. Grant, ready and channel outputs are combinational from the request inputs and the registered list.

Top module: `prio_grant_arbiter`

## Requirements
- R1: After reset, slot s of the list holds port s, so with every port requesting, channels 0, 1, 2 carry ports 0, 1, 2 (defaults: 6 ports, 3 channels).
- R2: Grants follow the list: the valid request in the earliest list slot is placed on channel 0, the next on channel 1, and so on.
- R3: No more requests are granted in a cycle than there are channels (NCHAN).
- R4: While fewer than NCHAN requests are granted, every valid port that appears in the list is granted.
- R5: Granted requests occupy channels 0..k-1 with no gap. Every unused channel has its valid bit low and its data and port fields at zero.
- R6: req_ready[p] is high exactly when port p is granted. It is never high for a port whose req_valid is low.
- R7: A configuration write with cfg_we high loads cfg_port into slot cfg_slot at the clock edge. Arbitration in the write cycle still uses the old list. The new entry applies from the next cycle, and other slots are unchanged.
- R8: A port listed in several slots is granted at most once per cycle and uses at most one channel.
- R9: Channel c reports in ch_port[c*PIDX_W +: PIDX_W] the index of the granted port. Its ch_data[c*PAYLOAD_W +: PAYLOAD_W] equals that port's req_data[p*PAYLOAD_W +: PAYLOAD_W].
- R10: A configuration write whose cfg_slot or cfg_port is not below NPORT leaves the whole list unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORT | Request valid per port |
| req_data | input | NPORT*PAYLOAD_W | Payload per port, port p at bits p*PAYLOAD_W |
| req_ready | output | NPORT | Grant per port this cycle |
| cfg_we | input | 1 | List slot write strobe |
| cfg_slot | input | PIDX_W | Slot to write |
| cfg_port | input | PIDX_W | Port index stored in the slot |
| ch_valid | output | NCHAN | Channel carries a granted request |
| ch_port | output | NCHAN*PIDX_W | Granted port index per channel |
| ch_data | output | NCHAN*PAYLOAD_W | Granted payload per channel |

## Verification
Directed cases try the identity list with all ports requesting, which separates list-ordered packing from index-ordered packing once the list is reversed. A sparse request set checks that the arbiter fills channels without gaps and still fills them when fewer requests than channels exist. A list filled with one repeated port shows whether duplicates are suppressed. Writes with out-of-range values check that illegal writes are dropped. Random request masks, payloads and slot rewrites mixed together then check, cycle by cycle, that a write takes effect only in the following cycle and that payloads follow their ports.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int unsigned DEF_NPORT     = 6;
    localparam int unsigned DEF_NCHAN     = 3;
    localparam int unsigned DEF_PAYLOAD_W = 16;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/prio_order_store.sv
module prio_order_store #(
    parameter int unsigned NPORT  = arb_pkg::DEF_NPORT,
    parameter int unsigned PIDX_W = arb_pkg::idx_width(NPORT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [PIDX_W-1:0]       cfg_slot,
    input  logic [PIDX_W-1:0]       cfg_port,
    output logic [NPORT*PIDX_W-1:0] order_o
);
    typedef struct packed {
        logic [NPORT-1:0][PIDX_W-1:0] order;
    } state_t;

    state_t st_d, st_q;
    logic   wr_legal;

    assign wr_legal = (32'(cfg_slot) < NPORT) && (32'(cfg_port) < NPORT);

    always_comb begin
        st_d = st_q;
        if (cfg_we && wr_legal) begin
            st_d.order[cfg_slot] = cfg_port;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NPORT); i++) begin
                st_q.order[i] <= PIDX_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar s = 0; s < int'(NPORT); s++) begin : g_flat
        assign order_o[s*PIDX_W +: PIDX_W] = st_q.order[s];
    end

    // R7
    slot_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wr_legal) |=> (st_q.order[$past(cfg_slot)] == $past(cfg_port)));

    // R10
    illegal_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !wr_legal) |=> $stable(st_q));

    // R7
    idle_list_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q));
endmodule

// File: rtl/grant_walker.sv
module grant_walker #(
    parameter int unsigned NPORT  = arb_pkg::DEF_NPORT,
    parameter int unsigned NCHAN  = arb_pkg::DEF_NCHAN,
    parameter int unsigned PIDX_W = arb_pkg::idx_width(NPORT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT*PIDX_W-1:0] order_i,
    input  logic [NPORT-1:0]        req_valid,
    output logic [NPORT-1:0]        grant_o,
    output logic [NCHAN-1:0]        chv_o,
    output logic [NCHAN*PIDX_W-1:0] chp_o
);
    logic [PIDX_W-1:0] p;
    int                used;

    always_comb begin
        grant_o = '0;
        chv_o   = '0;
        chp_o   = '0;
        used    = 0;
        p       = '0;
        for (int s = 0; s < int'(NPORT); s++) begin
            p = order_i[s*PIDX_W +: PIDX_W];
            if ((32'(p) < NPORT) && (used < int'(NCHAN))) begin
                if (req_valid[p] && !grant_o[p]) begin
                    grant_o[p]                    = 1'b1;
                    chv_o[used]                   = 1'b1;
                    chp_o[used*PIDX_W +: PIDX_W]  = p;
                    used                          = used + 1;
                end
            end
        end
    end

    // R3
    grant_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) <= NCHAN);

    // R6
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_valid) == '0);
endmodule

// File: rtl/channel_pack.sv
module channel_pack #(
    parameter int unsigned NPORT     = arb_pkg::DEF_NPORT,
    parameter int unsigned NCHAN     = arb_pkg::DEF_NCHAN,
    parameter int unsigned PAYLOAD_W = arb_pkg::DEF_PAYLOAD_W,
    parameter int unsigned PIDX_W    = arb_pkg::idx_width(NPORT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORT*PAYLOAD_W-1:0] req_data,
    input  logic [NCHAN-1:0]           chv_i,
    input  logic [NCHAN*PIDX_W-1:0]    chp_i,
    output logic [NCHAN*PAYLOAD_W-1:0] ch_data
);
    for (genvar c = 0; c < int'(NCHAN); c++) begin : g_chan
        logic [PIDX_W-1:0] sel;
        assign sel = chp_i[c*PIDX_W +: PIDX_W];

        always_comb begin
            ch_data[c*PAYLOAD_W +: PAYLOAD_W] = '0;
            if (chv_i[c] && (32'(sel) < NPORT)) begin
                ch_data[c*PAYLOAD_W +: PAYLOAD_W] = req_data[int'(sel)*PAYLOAD_W +: PAYLOAD_W];
            end
        end

        if (c + 1 < int'(NCHAN)) begin : g_gap
            // R5
            no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !chv_i[c] |-> !chv_i[c+1]);
        end

        // R5
        idle_chan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !chv_i[c] |-> (ch_data[c*PAYLOAD_W +: PAYLOAD_W] == '0));
    end
endmodule

// File: rtl/prio_grant_arbiter.sv
module prio_grant_arbiter #(
    parameter int unsigned NPORT     = arb_pkg::DEF_NPORT,
    parameter int unsigned NCHAN     = arb_pkg::DEF_NCHAN,
    parameter int unsigned PAYLOAD_W = arb_pkg::DEF_PAYLOAD_W,
    parameter int unsigned PIDX_W    = arb_pkg::idx_width(NPORT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORT-1:0]           req_valid,
    input  logic [NPORT*PAYLOAD_W-1:0] req_data,
    output logic [NPORT-1:0]           req_ready,
    input  logic                       cfg_we,
    input  logic [PIDX_W-1:0]          cfg_slot,
    input  logic [PIDX_W-1:0]          cfg_port,
    output logic [NCHAN-1:0]           ch_valid,
    output logic [NCHAN*PIDX_W-1:0]    ch_port,
    output logic [NCHAN*PAYLOAD_W-1:0] ch_data
);
    logic [NPORT*PIDX_W-1:0] order;

    prio_order_store #(.NPORT(NPORT), .PIDX_W(PIDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_slot(cfg_slot), .cfg_port(cfg_port), .order_o(order)
    );

    grant_walker #(.NPORT(NPORT), .NCHAN(NCHAN), .PIDX_W(PIDX_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .order_i(order), .req_valid(req_valid),
        .grant_o(req_ready), .chv_o(ch_valid), .chp_o(ch_port)
    );

    channel_pack #(.NPORT(NPORT), .NCHAN(NCHAN), .PAYLOAD_W(PAYLOAD_W), .PIDX_W(PIDX_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .req_data(req_data),
        .chv_i(ch_valid), .chp_i(ch_port), .ch_data(ch_data)
    );

    // R8
    one_chan_per_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ch_valid) == $countones(req_ready));
endmodule

// File: tb/prio_grant_arbiter_test.sv
`timescale 1ns/1ps
module prio_grant_arbiter_test;
    localparam int NPORT = 6;
    localparam int NCHAN = 3;
    localparam int PW    = 16;
    localparam int IW    = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NPORT-1:0]      req_valid = '0;
    logic [NPORT*PW-1:0]   req_data = '0;
    logic [NPORT-1:0]      req_ready;
    logic                  cfg_we = 1'b0;
    logic [IW-1:0]         cfg_slot = '0;
    logic [IW-1:0]         cfg_port = '0;
    logic [NCHAN-1:0]      ch_valid;
    logic [NCHAN*IW-1:0]   ch_port;
    logic [NCHAN*PW-1:0]   ch_data;

    int checks = 0;
    int failures = 0;
    int mdl_order [NPORT];

    always #2.5 clk = ~clk;

    prio_grant_arbiter #(.NPORT(NPORT), .NCHAN(NCHAN), .PAYLOAD_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_ready(req_ready), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_port(cfg_port),
        .ch_valid(ch_valid), .ch_port(ch_port), .ch_data(ch_data)
    );

    task automatic check_outputs(input string tag);
        logic [NCHAN-1:0]    ev;
        logic [NCHAN*IW-1:0] ep;
        logic [NCHAN*PW-1:0] ed;
        logic [NPORT-1:0]    er;
        bit                  taken [NPORT];
        int                  n;
        ev = '0; ep = '0; ed = '0; er = '0; n = 0;
        for (int i = 0; i < NPORT; i++) taken[i] = 0;
        for (int s = 0; s < NPORT; s++) begin
            int q;
            q = mdl_order[s];
            if (n < NCHAN && req_valid[q] && !taken[q]) begin
                taken[q] = 1;
                er[q] = 1'b1;
                ev[n] = 1'b1;
                ep[n*IW +: IW] = IW'(q);
                ed[n*PW +: PW] = req_data[q*PW +: PW];
                n++;
            end
        end
        checks++;
        if (ch_valid !== ev || ch_port !== ep || ch_data !== ed || req_ready !== er) begin
            failures++;
            $display("FAIL %s: valid=%b port=%h data=%h ready=%b expected valid=%b port=%h data=%h ready=%b",
                     tag, ch_valid, ch_port, ch_data, req_ready, ev, ep, ed, er);
        end
    endtask

    task automatic step(input logic [NPORT-1:0] v, input bit we, input int slot,
                        input int port, input string tag);
        @(negedge clk);
        req_valid = v;
        for (int i = 0; i < NPORT; i++) req_data[i*PW +: PW] = PW'($urandom);
        cfg_we   = we;
        cfg_slot = IW'(slot);
        cfg_port = IW'(port);
        #1;
        check_outputs(tag);
        @(posedge clk);
        if (we && slot < NPORT && port < NPORT) mdl_order[slot] = port;
        #0.1;
        cfg_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NPORT; i++) mdl_order[i] = i;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        step('0, 0, 0, 0, "R5 idle after reset");
        step('1, 0, 0, 0, "R1 identity order all requesting");
        step(6'b010010, 0, 0, 0, "R4 sparse requests fill channels");
        step(6'b000100, 0, 0, 0, "R5 single request on channel 0");
        for (int s = 0; s < NPORT; s++)
            step('1, 1, s, NPORT - 1 - s, "R7 slot rewrite applies next cycle");
        step('1, 0, 0, 0, "R2 reversed list order");
        step(6'b101011, 0, 0, 0, "R2 reversed list sparse");
        step('1, 1, 0, 2, "R7 write cycle uses old list");
        step('1, 0, 0, 0, "R7 new slot in use");
        for (int s = 0; s < NPORT; s++)
            step(6'b100001, 1, s, 5, "R8 filling list with one port");
        step('1, 0, 0, 0, "R8 duplicate port granted once");
        step('1, 1, 0, 7, "R10 illegal port index write");
        step('1, 1, 6, 0, "R10 illegal slot write");
        step('1, 0, 0, 0, "R10 list unchanged after illegal writes");
        step(6'b011110, 0, 0, 0, "R4 listed port absent leaves channels empty");

        for (int k = 0; k < 600; k++) begin
            bit we;
            we = ($urandom % 6) == 0;
            step(NPORT'($urandom), we, $urandom % 8, $urandom % 8, "R9 random payload routing");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule